// File: doc/BRIEF.md
# Sleep Entry and Recovery Sequencer

This block controls the low-power rest state of a synchronous memory. The sleep request comes in asynchronously and is active high. The block first brings it into the clock domain. It then waits a fixed number of cycles before it reports that the memory is asleep. Once the request drops, it waits a fixed number of cycles again and then holds a recovery window before it accepts ordinary accesses.

Input block starts at the entry countdown and stays on while the memory is asleep and while it is exiting. During block, no access can start, and any access already in progress is dropped. The data pins stay floated from the start of entry until recovery ends.

In the recovery window, a pulled-low address strobe or a full chip-select combination does not start an access. Instead it sets a violation flag that stays set until reset. While the memory is awake, the block qualifies access starts from the three chip selects and the two strobes. A stored word is never touched by sleep.

Top module: `sleep_sequencer`

## Requirements
- R1: After reset, asleep, in_block, rec_viol, data_float and acc_start are all 0, and the sequencer is awake.
- R2: If sleep_req is sampled high at clock edge k, asleep rises after edge k+4: two synchroniser cycles and then two entry cycles.
- R3: in_block rises after edge k+2 and stays high through entry, sleep and exit. While in_block is 1, acc_start is 0 and rec_viol does not change.
- R4: If sleep_req is sampled low at edge j while asleep, asleep falls after edge j+2 and in_block falls after edge j+4. A two-cycle recovery window then follows, and full access resumes after edge j+6.
- R5: If, during a recovery cycle, either strobe (cpu_as_n or ctl_as_n) is 0 or the chip is selected, rec_viol is set at that edge and stays 1 until reset. acc_start stays 0 during recovery.
- R6: data_float is 1 from the first entry cycle until recovery ends, which covers sleep and exit. It is 0 when awake.
- R7: When awake, acc_start is 1 exactly when the chip is selected and at least one strobe is low. The chip is selected when sel1_n=0, sel2=1 and sel3_n=0, so sel1_n=1 masks both strobes.
- R8: A recovery window with all strobes high and the chip deselected leaves rec_viol at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high; tie low when unused |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| cpu_as_n | input | 1 | Processor-side address strobe, active low |
| ctl_as_n | input | 1 | Controller-side address strobe, active low |
| asleep | output | 1 | Memory is in the sleep state |
| in_block | output | 1 | All access inputs are being ignored |
| rec_viol | output | 1 | Sticky flag: activity was seen during recovery |
| data_float | output | 1 | Data pins must be three-stated |
| acc_start | output | 1 | Qualified access start in this cycle |

## Verification
A wrong state register or counter shows up at the ports as a shifted edge on asleep, in_block or data_float. Each of these is checked every cycle around entry and exit, so a one-cycle slip in any latency fails on the edge where it occurs. A faulty recovery decode shows up differently in the two recovery runs. A false rec_viol appears after a quiet window. A missing rec_viol, or a nonzero acc_start, appears after an active window, one edge after the offending strobe.

// File: rtl/sleep_pkg.sv
// Shared types for the sleep sequencer.
package sleep_pkg;
    typedef enum logic [2:0] {
        ST_AWAKE   = 3'd0,
        ST_ENTER   = 3'd1,
        ST_SLEEP   = 3'd2,
        ST_EXIT    = 3'd3,
        ST_RECOVER = 3'd4
    } slp_state_t;
endpackage

// File: rtl/sleep_sync.sv
// Multi-flop synchroniser for the asynchronous sleep request.
// Assumes: STAGES >= 2; the reset value is the awake level (0).
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // shift one stage per clock
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= async_in;
                else chain[g] <= chain[(g > 0) ? g-1 : 0];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
// Entry / sleep / exit / recovery state machine with one shared down-counter.
// Assumes: every cycle count is at least 1; the request is already synchronised.
module sleep_fsm
    import sleep_pkg::*;
#(
    parameter int ENTER_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOVER_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    output slp_state_t state
);
    localparam int MAXC = (ENTER_CYC > EXIT_CYC) ?
                          ((ENTER_CYC > RECOVER_CYC) ? ENTER_CYC : RECOVER_CYC) :
                          ((EXIT_CYC > RECOVER_CYC) ? EXIT_CYC : RECOVER_CYC);
    localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] ENTER_LD = CW'(ENTER_CYC - 1);
    localparam logic [CW-1:0] EXIT_LD  = CW'(EXIT_CYC - 1);
    localparam logic [CW-1:0] REC_LD   = CW'(RECOVER_CYC - 1);

    logic [CW-1:0] cnt;
    logic          done;
    assign done = (cnt == '0);

    // advance the sequence and reload the counter at each phase change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_AWAKE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_AWAKE: if (req_s) begin
                    state <= ST_ENTER;
                    cnt   <= ENTER_LD;
                end
                ST_ENTER: if (done) state <= ST_SLEEP;
                          else      cnt   <= cnt - 1'b1;
                ST_SLEEP: if (!req_s) begin
                    state <= ST_EXIT;
                    cnt   <= EXIT_LD;
                end
                ST_EXIT: if (done) begin
                    state <= ST_RECOVER;
                    cnt   <= REC_LD;
                end else cnt <= cnt - 1'b1;
                ST_RECOVER: if (done) state <= ST_AWAKE;
                            else      cnt   <= cnt - 1'b1;
                default: begin
                    state <= ST_AWAKE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/access_gate.sv
// Qualifies access starts and records activity seen in the recovery window.
// Assumes: block and recover are never both high.
module access_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic block,
    input  logic recover,
    input  logic sel1_n,
    input  logic sel2,
    input  logic sel3_n,
    input  logic cpu_as_n,
    input  logic ctl_as_n,
    output logic acc_start,
    output logic rec_viol
);
    logic selected, strobe, activity;

    // decode chip select and strobe activity
    always_comb begin
        selected  = !sel1_n && sel2 && !sel3_n;
        strobe    = !cpu_as_n || !ctl_as_n;
        activity  = selected || strobe;
        acc_start = selected && strobe && !block && !recover;
    end

    // sticky flag for activity inside the recovery window
    always_ff @(posedge clk) begin
        if (!rst_n)                   rec_viol <= 1'b0;
        else if (recover && activity) rec_viol <= 1'b1;
    end
endmodule

// File: rtl/sleep_sequencer.sv
// Top: synchroniser, sequencing FSM and access gate for sleep control.
// Assumes: the caller deselects the chip before requesting sleep.
module sleep_sequencer
    import sleep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTER_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOVER_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic sel1_n,
    input  logic sel2,
    input  logic sel3_n,
    input  logic cpu_as_n,
    input  logic ctl_as_n,
    output logic asleep,
    output logic in_block,
    output logic rec_viol,
    output logic data_float,
    output logic acc_start
);
    logic       req_s;
    slp_state_t state;
    logic       recover;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sleep_req), .sync_out(req_s)
    );

    sleep_fsm #(
        .ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC), .RECOVER_CYC(RECOVER_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .state(state)
    );

    // decode state into port flags
    always_comb begin
        asleep     = (state == ST_SLEEP);
        in_block   = (state == ST_ENTER) || (state == ST_SLEEP) || (state == ST_EXIT);
        recover    = (state == ST_RECOVER);
        data_float = (state != ST_AWAKE);
    end

    access_gate u_gate (
        .clk(clk), .rst_n(rst_n), .block(in_block), .recover(recover),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .cpu_as_n(cpu_as_n), .ctl_as_n(ctl_as_n),
        .acc_start(acc_start), .rec_viol(rec_viol)
    );
endmodule

// File: rtl/sleep_sequencer_chk.sv
// Port-level properties of the sleep sequencer, bound to the top.
module sleep_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic sel1_n,
    input logic sel2,
    input logic sel3_n,
    input logic asleep,
    input logic in_block,
    input logic rec_viol,
    input logic data_float,
    input logic acc_start
);
    // R3
    block_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_block |-> !acc_start);
    // R2
    sleep_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(in_block));
    // R4
    exit_keeps_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> in_block);
    // R5
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_viol |=> rec_viol);
    // R6
    float_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep || in_block) |-> data_float);
    // R7
    start_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start |-> (!sel1_n && sel2 && !sel3_n && !data_float));
endmodule

bind sleep_sequencer sleep_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .asleep(asleep), .in_block(in_block), .rec_viol(rec_viol),
    .data_float(data_float), .acc_start(acc_start)
);

// File: tb/sleep_sequencer_bench.sv
module sleep_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    // input vectors {sel1_n, sel2, sel3_n, cpu_as_n, ctl_as_n}
    localparam logic [4:0] IDLE   = 5'b10111;
    localparam logic [4:0] SEL_CP = 5'b01001;
    localparam logic [4:0] SEL_CT = 5'b01010;
    localparam logic [4:0] MASK1  = 5'b11000;
    localparam logic [4:0] NOSEL2 = 5'b00001;

    logic clk = 0, rst_n = 0, sleep_req = 0;
    logic sel1_n = 1, sel2 = 0, sel3_n = 1, cpu_as_n = 1, ctl_as_n = 1;
    logic asleep, in_block, rec_viol, data_float, acc_start;
    int total = 0, bad = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_sequencer u_sleep_sequencer (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .cpu_as_n(cpu_as_n), .ctl_as_n(ctl_as_n),
        .asleep(asleep), .in_block(in_block), .rec_viol(rec_viol),
        .data_float(data_float), .acc_start(acc_start)
    );

    // expected vector {asleep, in_block, rec_viol, data_float, acc_start}
    task automatic compare(input logic [4:0] exp, input string tag);
        logic [4:0] act;
        act = {asleep, in_block, rec_viol, data_float, acc_start};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: set inputs before the next edge and queue the outcome after it
    task automatic step(input logic req, input logic [4:0] ins,
                        input logic [4:0] exp, input string tag);
        @(negedge clk);
        sleep_req = req;
        {sel1_n, sel2, sel3_n, cpu_as_n, ctl_as_n} = ins;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // monitor: pop and compare shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 compare(5'b00000, "R1 in reset");
        @(negedge clk) rst_n = 1;
        step(0, IDLE,   5'b00000, "R1 after reset");
        step(0, SEL_CP, 5'b00001, "R7 cpu strobe selected");
        step(0, SEL_CT, 5'b00001, "R7 ctl strobe selected");
        step(0, MASK1,  5'b00000, "R7 sel1_n masks strobes");
        step(0, NOSEL2, 5'b00000, "R7 sel2 low deselects");
        // entry, sleep request sampled at edge k
        step(1, IDLE,   5'b00000, "R2 edge k awake");
        step(1, IDLE,   5'b00000, "R2 edge k+1 awake");
        step(1, IDLE,   5'b01010, "R3 edge k+2 block");
        step(1, SEL_CP, 5'b01010, "R3 pending access dropped");
        step(1, IDLE,   5'b11010, "R2 edge k+4 asleep");
        step(1, SEL_CT, 5'b11010, "R3 ignored while asleep");
        step(1, MASK1,  5'b11010, "R6 float while asleep");
        // exit, request sampled low at edge j, quiet recovery
        step(0, IDLE,   5'b11010, "R4 edge j asleep");
        step(0, IDLE,   5'b11010, "R4 edge j+1 asleep");
        step(0, IDLE,   5'b01010, "R4 edge j+2 exit");
        step(0, IDLE,   5'b01010, "R4 edge j+3 exit");
        step(0, IDLE,   5'b00010, "R8 edge j+4 quiet recovery");
        step(0, IDLE,   5'b00010, "R8 edge j+5 quiet recovery");
        step(0, IDLE,   5'b00000, "R8 awake no violation");
        step(0, SEL_CP, 5'b00001, "R4 access resumes");
        // second sleep with activity during recovery
        step(1, IDLE, 5'b00000, "R2 second entry k");
        step(1, IDLE, 5'b00000, "R2 second entry k+1");
        step(1, IDLE, 5'b01010, "R3 second entry k+2");
        step(1, IDLE, 5'b01010, "R3 second entry k+3");
        step(1, IDLE, 5'b11010, "R2 second asleep");
        step(0, IDLE, 5'b11010, "R4 second exit j");
        step(0, IDLE, 5'b11010, "R4 second exit j+1");
        step(0, IDLE, 5'b01010, "R4 second exit j+2");
        step(0, IDLE, 5'b01010, "R4 second exit j+3");
        step(0, IDLE,   5'b00010, "R5 recovery first cycle");
        step(0, SEL_CP, 5'b00110, "R5 strobe in recovery flagged, no start");
        step(0, IDLE,   5'b00100, "R5 flag sticky after recovery");
        step(0, SEL_CT, 5'b00101, "R5 flag sticky, access works");
        step(0, IDLE,   5'b00100, "R5 flag still set");
        repeat (3) @(posedge clk);
        #2;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule